// File: doc/BRIEF.md
# Dot-clock DRAM access sequencer

This block turns one memory request into the multiplexed strobe sequence a dynamic RAM needs, fitting the whole access into the high half of the slow bus clock (PHI2). The fast dot clock is the block's clock. PHI2 is sampled on dot-clock edges, and an access can begin only on the first dot-clock edge that sees PHI2 high after it was low. Each later step of the access then falls on the next dot-clock edge.

Each access follows a fixed order. First the row half of the address goes onto the DRAM address pins, and write data is driven for a write. Then RAS goes low. Then the pins switch to the column half, and WE goes low for a write. Then CAS goes low. On the last step RAS, CAS and WE all go high together. A merged mode suits slower parts: it drops RAS and switches to the column address on the same edge, so the access is one edge shorter. For a read, the DRAM data bus is captured into a holding register on the edge that releases the strobes.

A transfer engine above this block presents the request, the direction, the mode and the address. Refresh is handled elsewhere.

Top module: `dram_access_seq`

## Requirements
- R1: While reset is held and right after it, RAS, CAS and WE are high (all three are active low), the data-drive enable is low and the read-valid flag is low.
- R2: An access starts only on a dot-clock edge where PHI2 is sampled high, PHI2 was sampled low on the previous edge, and the request is high. A request held while PHI2 stays low, or stays high, starts nothing. A request held over several PHI2 periods starts exactly one access per period.
- R3: In normal mode, with the start edge counted as edge 0, the sequence is as follows. From edge 0 the row address is on the pins. From edge 1 RAS is low. From edge 2 the column address is on the pins, with WE low for a write. From edge 3 CAS is low. At edge 4 the strobes are released.
- R4: In merged mode, RAS goes low, the column address appears and WE goes low for a write, all from edge 1. CAS goes low from edge 2, and the strobes are released at edge 3.
- R5: RAS, CAS and WE return high on the same edge, which is also the edge where the data-drive enable drops. CAS is never low while RAS is high.
- R6: For a write, the data-drive enable is high and the latched write data is on the data output from edge 0 until the release. For a read, WE and the data-drive enable stay inactive.
- R7: For a read, the DRAM data bus is captured on the release edge. The captured value appears on the read-data output together with a read-valid flag that is high for exactly one cycle. Writes never raise the flag.
- R8: The address, direction, mode and write data are latched on the start edge. The row is the upper half of the address and the column is the lower half. Changes on those inputs during an access have no effect on that access.
- R9: A request raised and dropped while an access is in progress, with no new PHI2 rise in between, starts no further access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Dot clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| phi2_i | input | 1 | Bus phase clock, sampled on clk_i |
| req_i | input | 1 | Access request |
| wr_i | input | 1 | 1 = write, 0 = read |
| merge_i | input | 1 | 1 = merged RAS/column mode |
| addr_i | input | ADDR_W | Full address; upper half is the row, lower half is the column |
| wdata_i | input | DATA_W | Write data |
| dram_addr_o | output | ADDR_W/2 | Multiplexed DRAM address |
| dram_ras_n_o | output | 1 | Row strobe, active low |
| dram_cas_n_o | output | 1 | Column strobe, active low |
| dram_we_n_o | output | 1 | Write enable, active low |
| dram_dq_o | output | DATA_W | Write data toward the DRAM |
| dram_dq_oe_o | output | 1 | Drive enable for dram_dq_o |
| dram_dq_i | input | DATA_W | Data from the DRAM |
| rd_data_o | output | DATA_W | Captured read data |
| rd_valid_o | output | 1 | One-cycle flag marking new read data |

## Verification
The assertions check the strobe relations on every cycle: CAS only while RAS is low, all strobes and the drive enable released together, WE only while the drive enable is high, the column address settled before CAS falls, and read-valid as a single-cycle pulse on the release edge. What only the bench scenarios can show is when and whether accesses start. That covers the number of starts for a held request over several PHI2 periods, no start with PHI2 frozen at either level, and a request dropped during an access being ignored. The bench also checks the exact edge of each step in both modes and that the latched address and data survive changes on the inputs.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ROW  = 3'd1,
    ST_RAS  = 3'd2,
    ST_COL  = 3'd3,
    ST_CAS  = 3'd4
  } seq_state_e;

  function automatic logic in_ras(seq_state_e s);
    return (s == ST_RAS) || (s == ST_COL) || (s == ST_CAS);
  endfunction

  function automatic logic in_col(seq_state_e s);
    return (s == ST_COL) || (s == ST_CAS);
  endfunction
endpackage

// File: rtl/phi2_rise_det.sv
module phi2_rise_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic phi2_i,
  output logic rise_o
);
  logic phi2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phi2_q <= 1'b0;
    else         phi2_q <= phi2_i;
  end

  assign rise_o = phi2_i & ~phi2_q;
endmodule

// File: rtl/dram_seq_fsm.sv
module dram_seq_fsm
  import dram_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       merge_q_i,
  output seq_state_e state_o,
  output logic       release_o
);
  seq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = ST_ROW;
      ST_ROW:  state_d = merge_q_i ? ST_COL : ST_RAS;
      ST_RAS:  state_d = ST_COL;
      ST_COL:  state_d = ST_CAS;
      ST_CAS:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o   = state_q;
  assign release_o = (state_q == ST_CAS);
endmodule

// File: rtl/dram_addr_path.sv
module dram_addr_path
  import dram_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  localparam int HALF_W = ADDR_W / 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              wr_i,
  input  logic              merge_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  seq_state_e        state_i,
  output logic              wr_q_o,
  output logic              merge_q_o,
  output logic [HALF_W-1:0] dram_addr_o,
  output logic [DATA_W-1:0] dram_dq_o
);
  logic [HALF_W-1:0] row_q, col_q;
  logic [DATA_W-1:0] wdata_q;
  logic              wr_q, merge_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_q   <= '0;
      col_q   <= '0;
      wdata_q <= '0;
      wr_q    <= 1'b0;
      merge_q <= 1'b0;
    end else if (start_i) begin
      row_q   <= addr_i[ADDR_W-1:HALF_W];
      col_q   <= addr_i[HALF_W-1:0];
      wdata_q <= wdata_i;
      wr_q    <= wr_i;
      merge_q <= merge_i;
    end
  end

  assign dram_addr_o = in_col(state_i) ? col_q : row_q;
  assign dram_dq_o   = wdata_q;
  assign wr_q_o      = wr_q;
  assign merge_q_o   = merge_q;
endmodule

// File: rtl/dram_rd_capture.sv
module dram_rd_capture #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              release_i,
  input  logic              wr_q_i,
  input  logic [DATA_W-1:0] dram_dq_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_valid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_data_o  <= '0;
      rd_valid_o <= 1'b0;
    end else begin
      rd_valid_o <= release_i & ~wr_q_i;
      if (release_i && !wr_q_i) rd_data_o <= dram_dq_i;
    end
  end
endmodule

// File: rtl/dram_access_seq.sv
module dram_access_seq
  import dram_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  localparam int HALF_W = ADDR_W / 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              phi2_i,
  input  logic              req_i,
  input  logic              wr_i,
  input  logic              merge_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [HALF_W-1:0] dram_addr_o,
  output logic              dram_ras_n_o,
  output logic              dram_cas_n_o,
  output logic              dram_we_n_o,
  output logic [DATA_W-1:0] dram_dq_o,
  output logic              dram_dq_oe_o,
  input  logic [DATA_W-1:0] dram_dq_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_valid_o
);
  logic       phi2_rise, start, release_pls, wr_q, merge_q;
  seq_state_e state;

  phi2_rise_det u_rise (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .phi2_i (phi2_i),
    .rise_o (phi2_rise)
  );

  assign start = phi2_rise & req_i & (state == ST_IDLE);

  dram_seq_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .merge_q_i (merge_q),
    .state_o   (state),
    .release_o (release_pls)
  );

  dram_addr_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_path (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .wr_i        (wr_i),
    .merge_i     (merge_i),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .state_i     (state),
    .wr_q_o      (wr_q),
    .merge_q_o   (merge_q),
    .dram_addr_o (dram_addr_o),
    .dram_dq_o   (dram_dq_o)
  );

  dram_rd_capture #(.DATA_W(DATA_W)) u_cap (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .release_i  (release_pls),
    .wr_q_i     (wr_q),
    .dram_dq_i  (dram_dq_i),
    .rd_data_o  (rd_data_o),
    .rd_valid_o (rd_valid_o)
  );

  assign dram_ras_n_o = ~in_ras(state);
  assign dram_cas_n_o = (state != ST_CAS);
  assign dram_we_n_o  = ~(wr_q & in_col(state));
  assign dram_dq_oe_o = wr_q & (state != ST_IDLE);
endmodule

// File: rtl/dram_access_seq_chk.sv
module dram_access_seq_chk #(
  parameter int HALF_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [HALF_W-1:0] dram_addr_o,
  input logic              dram_ras_n_o,
  input logic              dram_cas_n_o,
  input logic              dram_we_n_o,
  input logic              dram_dq_oe_o,
  input logic              rd_valid_o
);
  AST_CAS_UNDER_RAS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dram_cas_n_o |-> !dram_ras_n_o); // R5

  AST_JOINT_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dram_ras_n_o) |-> dram_cas_n_o && dram_we_n_o && $past(!dram_cas_n_o)); // R5

  AST_OE_DROPS_AT_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dram_dq_oe_o) |-> $rose(dram_ras_n_o)); // R5

  AST_WE_ONLY_DRIVING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dram_we_n_o |-> dram_dq_oe_o); // R6

  AST_COL_SETTLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dram_cas_n_o) |-> $stable(dram_addr_o) && $past(!dram_ras_n_o)); // R3

  AST_RD_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |=> !rd_valid_o); // R7

  AST_RD_AT_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> $rose(dram_ras_n_o) && !dram_dq_oe_o); // R7
endmodule

bind dram_access_seq dram_access_seq_chk #(.HALF_W(HALF_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .dram_addr_o  (dram_addr_o),
  .dram_ras_n_o (dram_ras_n_o),
  .dram_cas_n_o (dram_cas_n_o),
  .dram_we_n_o  (dram_we_n_o),
  .dram_dq_oe_o (dram_dq_oe_o),
  .rd_valid_o   (rd_valid_o)
);

// File: tb/dram_access_seq_tb.sv
`timescale 1ns/1ps
module dram_access_seq_tb;
  localparam int AW = 16;
  localparam int DW = 8;
  localparam int HW = AW / 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          phi2 = 1'b0, req = 1'b0, wr = 1'b0, merge = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0, dq_in = '0;
  logic [HW-1:0] d_addr;
  logic          ras_n, cas_n, we_n, oe, rd_valid;
  logic [DW-1:0] dq_out, rd_data;

  int checks = 0, fails = 0;
  bit phi2_run = 1'b0;
  int pcnt = 0;

  always #4 clk = ~clk;

  dram_access_seq #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .phi2_i(phi2), .req_i(req), .wr_i(wr),
    .merge_i(merge), .addr_i(addr), .wdata_i(wdata), .dram_addr_o(d_addr),
    .dram_ras_n_o(ras_n), .dram_cas_n_o(cas_n), .dram_we_n_o(we_n),
    .dram_dq_o(dq_out), .dram_dq_oe_o(oe), .dram_dq_i(dq_in),
    .rd_data_o(rd_data), .rd_valid_o(rd_valid)
  );

  // reference model
  bit          m_busy, m_prev, m_wr, m_fast, m_rdv;
  int          m_k, m_starts, obs_starts;
  logic [AW-1:0] m_addr;
  logic [DW-1:0] m_wdata, m_rdata;
  logic          ras_prev = 1'b1;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_prev = 0; m_rdv = 0; m_k = 0; m_rdata = '0;
    end else begin
      m_rdv = 0;
      if (!m_busy) begin
        if (phi2 && !m_prev && req) begin
          m_busy = 1; m_k = 0; m_wr = wr; m_fast = merge;
          m_addr = addr; m_wdata = wdata; m_starts++;
        end
      end else if (m_k == (m_fast ? 2 : 3)) begin
        m_busy = 0;
        if (!m_wr) begin m_rdv = 1; m_rdata = dq_in; end
      end else m_k++;
      m_prev = phi2;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      bit e_ras, e_col, e_cas, e_we, e_oe;
      e_ras = m_busy && m_k >= 1;
      e_col = m_busy && m_k >= (m_fast ? 1 : 2);
      e_cas = m_busy && m_k >= (m_fast ? 2 : 3);
      e_we  = e_col && m_wr;
      e_oe  = m_busy && m_wr;
      chk({ras_n, cas_n, we_n} == {!e_ras, !e_cas, !e_we}, m_fast ? "R4" : "R3",
          "strobes", {ras_n, cas_n, we_n}, {!e_ras, !e_cas, !e_we});
      chk(oe == e_oe, "R6", "drive enable", oe, e_oe);
      if (e_oe) chk(dq_out == m_wdata, "R6", "write data", dq_out, m_wdata);
      if (m_busy)
        chk(d_addr == (e_col ? m_addr[HW-1:0] : m_addr[AW-1:HW]), "R8", "dram addr",
            d_addr, e_col ? m_addr[HW-1:0] : m_addr[AW-1:HW]);
      chk(rd_valid == m_rdv, "R7", "read valid", rd_valid, m_rdv);
      if (m_rdv) chk(rd_data == m_rdata, "R7", "read data", rd_data, m_rdata);
      if (!ras_prev && ras_n)
        chk(cas_n && we_n && !oe, "R5", "joint release", {cas_n, we_n, oe}, 3'b110);
      if (ras_prev && !ras_n) obs_starts++;
      ras_prev = ras_n;
    end
  end

  // phi2 and DRAM bus stimulus
  initial forever begin
    @(negedge clk);
    dq_in = DW'($urandom);
    if (phi2_run) begin
      if (pcnt == 7) begin pcnt = 0; phi2 = ~phi2; end
      else pcnt++;
    end
  end

  task automatic do_access(input bit w, input bit f, input logic [AW-1:0] a,
                           input logic [DW-1:0] d);
    do @(posedge clk); while (phi2);
    @(negedge clk);
    req = 1; wr = w; merge = f; addr = a; wdata = d;
    do @(posedge clk); while (!phi2);
    @(negedge clk);
    req = 0; wr = ~w; merge = ~f; addr = ~a; wdata = ~d;   // R8 disturb
    repeat (6) @(negedge clk);
  endtask

  initial begin
    int s0;
    repeat (3) @(negedge clk);
    chk(ras_n && cas_n && we_n && !oe && !rd_valid, "R1", "reset outputs",
        {ras_n, cas_n, we_n, oe, rd_valid}, 5'b11100);
    rst_n = 1;
    @(negedge clk);
    chk(ras_n && cas_n && we_n && !oe && !rd_valid, "R1", "after reset",
        {ras_n, cas_n, we_n, oe, rd_valid}, 5'b11100);
    phi2_run = 1;

    do_access(1, 0, 16'h12A5, 8'h3C);
    do_access(0, 0, 16'hF00F, 8'h00);
    do_access(1, 0, 16'h8001, 8'hFF);
    do_access(0, 1, 16'h55AA, 8'h00);
    do_access(1, 1, 16'hC3E7, 8'h96);
    do_access(0, 0, 16'h0000, 8'h00);

    // R2: held request, four periods -> four accesses
    do @(posedge clk); while (phi2);
    @(negedge clk);
    s0 = obs_starts; req = 1; wr = 0; merge = 0; addr = 16'h4321;
    repeat (64) @(negedge clk);
    req = 0;
    repeat (10) @(negedge clk);
    chk(obs_starts - s0 == 4, "R2", "held request starts", obs_starts - s0, 4);

    // R2: phi2 frozen low, then frozen high
    do @(posedge clk); while (phi2);
    @(negedge clk);
    phi2_run = 0; phi2 = 0; s0 = obs_starts; req = 1;
    repeat (30) @(negedge clk);
    chk(obs_starts == s0, "R2", "no rise low", obs_starts - s0, 0);
    phi2 = 1;
    repeat (40) @(negedge clk);
    chk(obs_starts - s0 == 1, "R2", "frozen high", obs_starts - s0, 1);
    req = 0;
    repeat (4) @(negedge clk);
    phi2 = 0; pcnt = 0; phi2_run = 1;

    // R9: request pulse during an access
    do @(posedge clk); while (phi2);
    @(negedge clk);
    s0 = obs_starts; req = 1; wr = 1; merge = 0; addr = 16'hBEEF; wdata = 8'h5A;
    do @(posedge clk); while (!phi2);
    @(negedge clk); req = 0;
    @(negedge clk); req = 1;
    repeat (2) @(negedge clk); req = 0;
    repeat (20) @(negedge clk);
    chk(obs_starts - s0 == 1, "R9", "pulse during busy", obs_starts - s0, 1);
    chk(obs_starts == m_starts, "R2", "start count", obs_starts, m_starts);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule